// File: doc/BRIEF.md
# Code Jump Error Monitor

This block watches a stream of converter output codes captured while the analog input is a slow ramp, one that moves by less than one code per sample. Under that condition any large step between two successive codes cannot come from the signal. It is treated as a word error (for example, a sparkle code from a faulty thermometer decode). The host sets a qualified level, an error-count limit and a sample-count limit, then pulses `start`. The block accepts codes over a valid/ready stream. It flags each code whose absolute step from the previous accepted code is larger than the level. It keeps a running total of examined samples and of flagged samples.

The run ends on whichever limit is reached first. A `done` flag rises, and a cause bit records whether the error limit or the sample limit ended the run. The host divides the two totals to form the word error rate. Around the first flagged code of a run, the block freezes a 17-entry context window for later inspection: eight codes before it, the code itself, and eight codes after it. The host reads the window through a plain address/data port.

Stream rules: a code is taken on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only while a run is active. It goes low in the cycle `start` is asserted and stays low once `done` is set. A producer that holds `s_valid` while `s_ready` is low loses nothing; its code simply waits. Limits and level must be held steady during a run.

Top module: `code_jump_monitor`

## Requirements
- R1: After reset, `done`, `stop_on_errors`, `s_ready`, `win_captured` and both counters are 0, and every window address reads 0.
- R2: A code is consumed only on a rising edge with `s_valid` and `s_ready` both high. `s_ready` is low while no run is active, in any cycle with `start` high, and once `done` is set. Codes offered while it is low change neither counter.
- R3: The first code accepted after `start` has no predecessor. It is neither examined nor flagged, and the sample counter counts from the second accepted code onward.
- R4: An examined code is flagged when the absolute difference from the previous accepted code is strictly greater than `qual_level`. With a level of 2, a step of 3 is an error and a step of 2 is not.
- R5: `sample_count` equals the number of examined codes and `err_count` the number of flagged codes. Both update on the accepting edge.
- R6: When `err_count` reaches a nonzero `err_limit`, `done` and `stop_on_errors` become 1 on that same edge. If both limits are met by the same code, `stop_on_errors` is 1.
- R7: When `sample_count` reaches a nonzero `sample_limit` and the error limit is not met on that code, `done` becomes 1 with `stop_on_errors` 0.
- R8: A limit value of 0 disables that limit.
- R9: Both counters saturate at all ones instead of wrapping.
- R10: Window addresses 0 to 7 hold the eight codes accepted before the first flagged code, oldest at address 0. Addresses with no such code read 0. Address 8 holds the first flagged code.
- R11: Addresses 9 to 16 hold the codes accepted after the first flagged code, in order. Slots not reached before the run ends read 0. Only the first flagged code of a run is captured, and `win_captured` rises on its accepting edge. Addresses 17 and above read 0.
- R12: `start` restarts the block at any time. It clears both counters, `done`, the cause bit, the window and the predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle pulse that begins a new run |
| qual_level | input | DW | Largest step still accepted as good |
| err_limit | input | CNT_W | Error count that ends the run, 0 disables |
| sample_limit | input | CNT_W | Examined-sample count that ends the run, 0 disables |
| s_valid | input | 1 | Stream code valid |
| s_ready | output | 1 | Stream ready |
| s_code | input | DW | Converter output code |
| done | output | 1 | Run ended on a limit |
| stop_on_errors | output | 1 | 1: error limit ended the run, 0: sample limit |
| err_count | output | CNT_W | Flagged codes, saturating |
| sample_count | output | CNT_W | Examined codes, saturating |
| win_captured | output | 1 | Context window holds a first error |
| win_addr | input | WA | Window read address |
| win_data | output | DW | Window read data |

## Verification
The bench sweeps every step from -6 to +6 against levels 0 to 4. A design that used greater-or-equal, or a signed difference, would misjudge the steps that equal the level or the negative steps. Other runs place the first error at the second accepted code and end on the error limit at once. This catches a window that does not zero its missing pre-entries, or that does not leave its post-entries blank, and a tie between the limits that reports the wrong cause. A 300-code run with both limits disabled and an error on every step shows whether the 8-bit counters wrap or stop. A restart in mid-run, plus codes offered after `done`, expose any stale predecessor or any consumption past the end.

// File: rtl/cjm_pkg.sv
package cjm_pkg;
  // Cause of run termination, reported on stop_on_errors.
  typedef enum logic {
    STOP_BY_SAMPLES = 1'b0,
    STOP_BY_ERRORS  = 1'b1
  } stop_cause_e;
endpackage

// File: rtl/cjm_sat_counter.sv
module cjm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic [W-1:0] count_next
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  // Next value exposed so limit compares can act on the same edge.
  always_comb begin
    count_next = count;
    if (inc && (count != MAXV)) count_next = count + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count_next;
  end
endmodule

// File: rtl/cjm_jump_detect.sv
module cjm_jump_detect #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  input  logic [DW-1:0] level,
  output logic          jump
);
  logic [DW-1:0] mag;

  // Unsigned magnitude of the step, compared strictly against the level.
  always_comb begin
    mag  = (cur >= prev) ? (cur - prev) : (prev - cur);
    jump = (mag > level);
  end
endmodule

// File: rtl/cjm_context_window.sv
module cjm_context_window #(
  parameter  int DW   = 8,
  parameter  int PRE  = 8,
  parameter  int POST = 8,
  localparam int WIN  = PRE + 1 + POST,
  localparam int AW   = $clog2(WIN),
  localparam int PW   = $clog2(PRE),
  localparam int CW   = $clog2(POST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          trigger,
  input  logic [DW-1:0] code,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          captured
);
  logic [DW-1:0] ring    [PRE];
  logic [DW-1:0] ordered [PRE];
  logic [DW-1:0] win     [WIN];
  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_nx;
  logic [CW-1:0] post_cnt;
  logic [AW-1:0] post_idx;

  assign wptr_nx  = (wptr == PW'(PRE - 1)) ? '0 : wptr + PW'(1);
  assign post_idx = AW'(PRE + 1) + AW'(post_cnt);

  // Oldest-first view of the ring: slot wptr holds the oldest entry.
  for (genvar g = 0; g < PRE; g++) begin : g_order
    logic [PW:0] sum;
    assign sum        = {1'b0, wptr} + (PW+1)'(g);
    assign ordered[g] = (sum >= (PW+1)'(PRE)) ? ring[PW'(sum - (PW+1)'(PRE))]
                                                : ring[PW'(sum)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE; i++) ring[i] <= '0;
      for (int i = 0; i < WIN; i++) win[i]  <= '0;
      wptr     <= '0;
      post_cnt <= '0;
      captured <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i < PRE; i++) ring[i] <= '0;
      for (int i = 0; i < WIN; i++) win[i]  <= '0;
      wptr     <= '0;
      post_cnt <= '0;
      captured <= 1'b0;
    end else if (push) begin
      if (!captured) begin
        ring[wptr] <= code;
        wptr       <= wptr_nx;
        if (trigger) begin
          for (int i = 0; i < PRE; i++) win[i] <= ordered[i];
          win[PRE] <= code;
          captured <= 1'b1;
          post_cnt <= '0;
        end
      end else if (post_cnt < CW'(POST)) begin
        win[post_idx] <= code;
        post_cnt      <= post_cnt + CW'(1);
      end
    end
  end

  assign rd_data = (rd_addr < AW'(WIN)) ? win[rd_addr] : '0;
endmodule

// File: rtl/code_jump_monitor.sv
module code_jump_monitor
  import cjm_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int CNT_W = 32,
  parameter  int PRE   = 8,
  parameter  int POST  = 8,
  localparam int WIN   = PRE + 1 + POST,
  localparam int WA    = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    qual_level,
  input  logic [CNT_W-1:0] err_limit,
  input  logic [CNT_W-1:0] sample_limit,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_code,
  output logic             done,
  output logic             stop_on_errors,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] sample_count,
  output logic             win_captured,
  input  logic [WA-1:0]    win_addr,
  output logic [DW-1:0]    win_data
);
  logic             running;
  logic             have_prev;
  logic [DW-1:0]    prev_code;
  stop_cause_e      cause_q;
  logic             accept;
  logic             examine;
  logic             jump;
  logic             err_hit;
  logic             smp_hit;
  logic [CNT_W-1:0] smp_next;
  logic [CNT_W-1:0] err_next;

  assign s_ready = running & ~start;
  assign accept  = s_valid & s_ready;
  assign examine = accept & have_prev;

  cjm_jump_detect #(.DW(DW)) u_jump (
    .cur   (s_code),
    .prev  (prev_code),
    .level (qual_level),
    .jump  (jump)
  );

  cjm_sat_counter #(.W(CNT_W)) u_smp_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .inc        (examine),
    .count      (sample_count),
    .count_next (smp_next)
  );

  cjm_sat_counter #(.W(CNT_W)) u_err_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .inc        (examine & jump),
    .count      (err_count),
    .count_next (err_next)
  );

  cjm_context_window #(.DW(DW), .PRE(PRE), .POST(POST)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .push     (accept),
    .trigger  (examine & jump),
    .code     (s_code),
    .rd_addr  (win_addr),
    .rd_data  (win_data),
    .captured (win_captured)
  );

  // Limit hits evaluated on the counters' next values: stop on the same edge.
  assign err_hit = examine & jump & (err_limit != '0) & (err_next == err_limit);
  assign smp_hit = examine & (sample_limit != '0) & (smp_next == sample_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      done      <= 1'b0;
      cause_q   <= STOP_BY_SAMPLES;
      have_prev <= 1'b0;
      prev_code <= '0;
    end else if (start) begin
      running   <= 1'b1;
      done      <= 1'b0;
      cause_q   <= STOP_BY_SAMPLES;
      have_prev <= 1'b0;
      prev_code <= '0;
    end else if (accept) begin
      prev_code <= s_code;
      have_prev <= 1'b1;
      if (err_hit || smp_hit) begin
        running <= 1'b0;
        done    <= 1'b1;
        cause_q <= err_hit ? STOP_BY_ERRORS : STOP_BY_SAMPLES;
      end
    end
  end

  assign stop_on_errors = (cause_q == STOP_BY_ERRORS);
endmodule

// File: rtl/cjm_checker.sv
module cjm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] err_limit,
  input logic [CNT_W-1:0] sample_limit,
  input logic             s_ready,
  input logic             done,
  input logic             stop_on_errors,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] sample_count,
  input logic             win_captured
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_no_ready_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);

  assert_no_ready_in_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !s_ready);

  assert_frozen_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(sample_count) && $stable(err_count)));

  assert_errs_within_samples_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= sample_count);

  assert_sample_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((sample_count == $past(sample_count)) ||
                (sample_count == $past(sample_count) + ONE)));

  assert_err_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && stop_on_errors) |-> (err_count == err_limit));

  assert_smp_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !stop_on_errors) |-> (sample_count == sample_limit));

  assert_capture_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_captured && !start) |=> win_captured);
endmodule

bind code_jump_monitor cjm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .err_limit      (err_limit),
  .sample_limit   (sample_limit),
  .s_ready        (s_ready),
  .done           (done),
  .stop_on_errors (stop_on_errors),
  .err_count      (err_count),
  .sample_count   (sample_count),
  .win_captured   (win_captured)
);

// File: tb/code_jump_monitor_tb_top.sv
module code_jump_monitor_tb_top;
  localparam int DW = 8, CW = 8, PRE = 8, POST = 8, WIN = 17, WA = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, s_valid, s_ready, done, stop_on_errors, win_captured;
  logic [DW-1:0] qual_level, s_code, win_data;
  logic [CW-1:0] err_limit, sample_limit, err_count, sample_count;
  logic [WA-1:0] win_addr;

  code_jump_monitor #(.DW(DW), .CNT_W(CW), .PRE(PRE), .POST(POST)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .qual_level(qual_level),
    .err_limit(err_limit), .sample_limit(sample_limit), .s_valid(s_valid),
    .s_ready(s_ready), .s_code(s_code), .done(done), .stop_on_errors(stop_on_errors),
    .err_count(err_count), .sample_count(sample_count), .win_captured(win_captured),
    .win_addr(win_addr), .win_data(win_data)
  );

  int checks = 0, errors = 0, consumed = 0;
  int stim [0:511];
  int exp_err, exp_smp, exp_cons, exp_hit, exp_done, exp_reason;
  int exp_win [WIN];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int lvl, input int el, input int sl);
    @(negedge clk);
    qual_level = DW'(lvl); err_limit = CW'(el); sample_limit = CW'(sl);
    start = 1'b1;
    #1 chk("R2 ready low in start cycle", int'(s_ready), 0);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input int n, input bit gap);
    int idx = 0;
    int cyc = 0;
    bit acc;
    while (idx < n && !done) begin
      @(negedge clk);
      s_code  = DW'(stim[idx]);
      s_valid = !(gap && (cyc % 3 == 2));
      cyc++;
      #1 acc = s_valid && s_ready;
      @(posedge clk);
      #1;
      if (acc) idx++;
    end
    @(negedge clk);
    s_valid = 1'b0;
    consumed = idx;
  endtask

  task automatic model(input int n, input int lvl, input int el, input int sl);
    int maxc = (1 << CW) - 1;
    exp_err = 0; exp_smp = 0; exp_done = 0; exp_reason = 0; exp_cons = n; exp_hit = -1;
    for (int i = 1; i < n; i++) begin
      int d = stim[i] - stim[i-1];
      bit jmp = ((d < 0) ? -d : d) > lvl;
      if (exp_smp < maxc) exp_smp++;
      if (jmp && exp_err < maxc) exp_err++;
      if (jmp && exp_hit < 0) exp_hit = i;
      if (el != 0 && jmp && exp_err == el) begin
        exp_done = 1; exp_reason = 1; exp_cons = i + 1; break;
      end
      if (sl != 0 && exp_smp == sl) begin
        exp_done = 1; exp_cons = i + 1; break;
      end
    end
    for (int j = 0; j < WIN; j++) begin
      int k = exp_hit - PRE + j;
      if (exp_hit < 0)   exp_win[j] = 0;
      else if (j < PRE)  exp_win[j] = (k >= 0) ? stim[k] : 0;
      else if (j == PRE) exp_win[j] = stim[exp_hit];
      else               exp_win[j] = (k <= exp_cons - 1) ? stim[k] : 0;
    end
  endtask

  task automatic run_case(input string nm, input int n, input int lvl,
                          input int el, input int sl, input bit gap);
    do_start(lvl, el, sl);
    send(n, gap);
    model(n, lvl, el, sl);
    chk({nm, " R2 codes consumed"}, consumed, exp_cons);
    chk({nm, " R5 sample count"}, int'(sample_count), exp_smp);
    chk({nm, " R5 error count"}, int'(err_count), exp_err);
    chk({nm, " R6/R7 done"}, int'(done), exp_done);
    if (exp_done != 0) chk({nm, " R6/R7 cause"}, int'(stop_on_errors), exp_reason);
    chk({nm, " R11 captured flag"}, int'(win_captured), (exp_hit >= 0) ? 1 : 0);
    for (int j = 0; j < WIN; j++) begin
      @(negedge clk);
      win_addr = WA'(j);
      #1 chk($sformatf("%s R10/R11 window %0d", nm, j), int'(win_data), exp_win[j]);
    end
  endtask

  task automatic build_ramp(input int n);
    for (int i = 0; i < n; i++) stim[i] = 10 + i / 2;
    stim[20] = stim[20] + 40;
    stim[50] = stim[50] + 40;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; s_valid = 1'b0; s_code = '0;
    qual_level = '0; err_limit = '0; sample_limit = '0; win_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 done after reset", int'(done), 0);
    chk("R1 cause after reset", int'(stop_on_errors), 0);
    chk("R1 ready after reset", int'(s_ready), 0);
    chk("R1 sample count after reset", int'(sample_count), 0);
    chk("R1 error count after reset", int'(err_count), 0);
    chk("R1 captured after reset", int'(win_captured), 0);
    chk("R1 window after reset", int'(win_data), 0);

    // R3: a lone first code is never examined.
    stim[0] = 200;
    run_case("first", 1, 2, 0, 0, 1'b0);

    // R4: full step-versus-level sweep, one examined code per run.
    for (int lvl = 0; lvl <= 4; lvl++) begin
      for (int d = -6; d <= 6; d++) begin
        stim[0] = 100; stim[1] = 100 + d;
        do_start(lvl, 0, 1);
        send(2, 1'b0);
        chk($sformatf("R4 step %0d level %0d", d, lvl), int'(err_count),
            (((d < 0) ? -d : d) > lvl) ? 1 : 0);
        chk("R7 sample limit cause", int'(stop_on_errors), 0);
      end
    end

    // R6: ramp with two spikes, error limit 3 ends at code 50.
    build_ramp(120);
    run_case("errlim", 120, 2, 3, 200, 1'b1);
    // R7: same ramp, sample limit 30 ends first.
    run_case("smplim", 120, 2, 10, 30, 1'b0);
    // R6 tie and R10 zero pre-entries: error on the first examined code.
    stim[0] = 100; stim[1] = 110;
    run_case("tie", 5, 2, 1, 1, 1'b0);

    // R2: codes offered after done are not consumed.
    @(negedge clk);
    s_valid = 1'b1; s_code = 8'd7;
    repeat (5) @(negedge clk);
    chk("R2 ready after done", int'(s_ready), 0);
    chk("R2 samples frozen after done", int'(sample_count), 1);
    chk("R2 errors frozen after done", int'(err_count), 1);
    s_valid = 1'b0;

    // R8: limits disabled, early error with partial pre-history, gaps on valid.
    for (int i = 0; i < 40; i++) stim[i] = 60 + i / 3;
    stim[3] = 0;
    run_case("nolim", 40, 2, 0, 0, 1'b1);

    // R9: error on every step, counters must stop at 255.
    for (int i = 0; i < 300; i++) stim[i] = (i % 2) * 20;
    run_case("sat", 300, 2, 0, 0, 1'b0);

    // R12: restart in the middle of a run clears everything.
    build_ramp(30);
    do_start(2, 0, 0);
    send(30, 1'b0);
    chk("R12 pre-restart errors", int'(err_count), 2);
    do_start(2, 0, 0);
    #1;
    chk("R12 samples cleared", int'(sample_count), 0);
    chk("R12 errors cleared", int'(err_count), 0);
    chk("R12 done cleared", int'(done), 0);
    chk("R12 window cleared", int'(win_captured), 0);
    chk("R12 running again", int'(s_ready), 1);
    win_addr = WA'(PRE);
    #1 chk("R12 window entry cleared", int'(win_data), 0);
    win_addr = WA'(20);
    #1 chk("R11 address beyond window", int'(win_data), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule